// File: doc/BRIEF.md
# Base-16 Floating-Point Multiplier

This block multiplies two 32-bit floating-point words whose exponent base is sixteen. Each word holds a sign bit, a seven-bit exponent stored with an offset of 64, and a 24-bit unsigned fraction made of six hexadecimal digits. The fraction is a normalized value in [1/16, 1): its leading hex digit is nonzero. An all-zero fraction with a zero exponent field stands for zero.

A caller presents both operands with a single-cycle start pulse. One clock edge later the block raises a one-cycle done pulse and shows the product word along with overflow and underflow flags. These outputs stay unchanged until the next start. The result sign comes from the operand signs. The stored exponents are added, and the offset is removed by inverting the top bit of the seven-bit sum. The fractions are multiplied, the product is shifted left by one hex digit when its leading digit is zero, and the result is truncated to six digits.

Top module: `hexfp_mul`

## Requirements
- R1: The product sign (bit 31) is 0 when both operand signs are equal and 1 when they differ, for every nonzero, non-underflowing product.
- R2: When the leading hex digit of the full fraction product is nonzero, the stored result exponent (bits 30:24) equals ea + eb - 64, where ea and eb are the operand exponent fields.
- R3: When the leading hex digit of the fraction product is zero, the fraction is shifted left by four bits and the stored exponent equals ea + eb - 65.
- R4: The result fraction (bits 23:0) is the top 24 bits of the normalized 48-bit fraction product. Lower bits are dropped with no rounding.
- R5: When the result exponent would exceed 127 in stored form, the overflow flag is set and the word becomes the largest magnitude of the correct sign: exponent 7'h7F and fraction 24'hFFFFFF.
- R6: When the result exponent would fall below 0 in stored form, including through the normalization decrement, the underflow flag is set and the word is all zeros.
- R7: When either operand fraction is zero, the word is all zeros and both flags are clear.
- R8: After reset, done, the word and both flags are zero. Done is high exactly in the cycle after a start. The word and both flags hold their values while start is low.
- R9: Overflow and underflow are never raised together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Single-cycle strobe that captures both operands |
| opa_i | input | 32 | First operand word |
| opb_i | input | 32 | Second operand word |
| prod_o | output | 32 | Product word |
| done_o | output | 1 | High for one cycle when prod_o is updated |
| ovf_o | output | 1 | Exponent overflow for the last product |
| unf_o | output | 1 | Exponent underflow for the last product |

## Verification
All results, including the word, both flags and done, are due on the first clock edge after the edge that samples start. The bench drives start on a falling edge and reads every output on the next falling edge, half a period after the capturing edge. It then drops start and reads again one cycle later, to confirm that done has fallen and that the word and flags are unchanged. Expected values come from integer arithmetic on the true exponents, -64 to +63, and on the 48-bit fraction product. The sweep covers exponent pairs at the range edges with fractions that do and do not need normalization.

// File: rtl/hexfp_pkg.sv
// Shared sizing for the base-16 multiplier.
// Assumes the exponent offset is half the exponent code range.
package hexfp_pkg;
    parameter int EXP_W  = 7;
    parameter int DIG_W  = 4;
    parameter int NDIG   = 6;
    localparam int FRAC_W = NDIG * DIG_W;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int KEEP_W = FRAC_W + DIG_W;
endpackage

// File: rtl/hexfp_sig_mul.sv
// Fraction multiplier with one-digit postnormalization.
// Assumes both fractions are normalized (leading digit nonzero), so the
// product needs at most one left shift of one digit.
module hexfp_sig_mul #(
    parameter int FRAC_W = hexfp_pkg::FRAC_W,
    parameter int DIG_W  = hexfp_pkg::DIG_W
) (
    input  logic [FRAC_W-1:0] ma_i,
    input  logic [FRAC_W-1:0] mb_i,
    output logic [FRAC_W-1:0] frac_o,
    output logic              shift_o
);
    localparam int PROD_W = 2 * FRAC_W;
    localparam int KEEP_W = FRAC_W + DIG_W;

    logic [PROD_W-1:0] prod;
    logic [KEEP_W-1:0] keep;

    // Full product, then keep one spare digit below the six result digits.
    always_comb begin
        prod = ma_i * mb_i;
        keep = prod[PROD_W-1 -: KEEP_W];
    end

    // Normalize: drop a zero leading digit, then truncate to six digits.
    always_comb begin
        shift_o = (keep[KEEP_W-1 -: DIG_W] == '0);
        frac_o  = shift_o ? keep[FRAC_W-1:0] : keep[KEEP_W-1 -: FRAC_W];
    end
endmodule

// File: rtl/hexfp_exp_unit.sv
// Exponent adder with offset removal and range checks.
// Assumes the offset is 2^(EXP_W-1). It is removed by inverting the top
// bit of the low EXP_W sum bits, with range bits rebuilt above them.
module hexfp_exp_unit #(
    parameter int EXP_W = hexfp_pkg::EXP_W
) (
    input  logic [EXP_W-1:0] ea_i,
    input  logic [EXP_W-1:0] eb_i,
    input  logic             shift_i,
    output logic [EXP_W-1:0] exp_o,
    output logic             ovf_o,
    output logic             unf_o
);
    localparam int EXT_W = EXP_W + 2;

    logic [EXP_W:0]   sum;
    logic [1:0]       hi;
    logic [EXT_W-1:0] rebased;
    logic [EXT_W-1:0] adj;

    // Sum the stored exponents and remove the offset once.
    always_comb begin
        sum = {1'b0, ea_i} + {1'b0, eb_i};
        unique case (sum[EXP_W:EXP_W-1])
            2'b00:   hi = 2'b11;
            2'b11:   hi = 2'b01;
            default: hi = 2'b00;
        endcase
        rebased = {hi, ~sum[EXP_W-1], sum[EXP_W-2:0]};
    end

    // Apply the normalization decrement and classify the range.
    always_comb begin
        adj   = rebased - {{(EXT_W-1){1'b0}}, shift_i};
        unf_o = adj[EXT_W-1];
        ovf_o = ~adj[EXT_W-1] & adj[EXT_W-2];
        exp_o = adj[EXP_W-1:0];
    end
endmodule

// File: rtl/hexfp_pack.sv
// Result word assembly: zero, saturation, flush-to-zero or a normal word.
// Assumes the overflow and underflow inputs are mutually exclusive.
module hexfp_pack #(
    parameter int EXP_W  = hexfp_pkg::EXP_W,
    parameter int FRAC_W = hexfp_pkg::FRAC_W
) (
    input  logic                      zero_i,
    input  logic                      sign_i,
    input  logic [EXP_W-1:0]          exp_i,
    input  logic [FRAC_W-1:0]         frac_i,
    input  logic                      ovf_i,
    input  logic                      unf_i,
    output logic [EXP_W+FRAC_W:0]     word_o,
    output logic                      ovf_o,
    output logic                      unf_o
);
    // Pick the output encoding in priority order: zero, underflow, overflow.
    always_comb begin
        ovf_o = 1'b0;
        unf_o = 1'b0;
        if (zero_i) begin
            word_o = '0;
        end else if (unf_i) begin
            word_o = '0;
            unf_o  = 1'b1;
        end else if (ovf_i) begin
            word_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b1}}};
            ovf_o  = 1'b1;
        end else begin
            word_o = {sign_i, exp_i, frac_i};
        end
    end
endmodule

// File: rtl/hexfp_mul.sv
// Top of the base-16 multiplier: one registered stage from start to done.
// Assumes nonzero operands are normalized. Outputs hold between starts.
module hexfp_mul #(
    parameter int EXP_W  = hexfp_pkg::EXP_W,
    parameter int FRAC_W = hexfp_pkg::FRAC_W,
    parameter int WORD_W = hexfp_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] opa_i,
    input  logic [WORD_W-1:0] opb_i,
    output logic [WORD_W-1:0] prod_o,
    output logic              done_o,
    output logic              ovf_o,
    output logic              unf_o
);
    logic [FRAC_W-1:0] frac;
    logic              shift;
    logic [EXP_W-1:0]  exp_n;
    logic              ovf_raw, unf_raw;
    logic              zero_in, sign;
    logic [WORD_W-1:0] word_n;
    logic              ovf_n, unf_n;

    // Zero detection on either fraction, and sign from the operand signs.
    always_comb begin
        zero_in = (opa_i[FRAC_W-1:0] == '0) || (opb_i[FRAC_W-1:0] == '0);
        sign    = opa_i[WORD_W-1] ^ opb_i[WORD_W-1];
    end

    hexfp_sig_mul #(.FRAC_W(FRAC_W)) u_sig (
        .ma_i    (opa_i[FRAC_W-1:0]),
        .mb_i    (opb_i[FRAC_W-1:0]),
        .frac_o  (frac),
        .shift_o (shift)
    );

    hexfp_exp_unit #(.EXP_W(EXP_W)) u_exp (
        .ea_i    (opa_i[WORD_W-2 -: EXP_W]),
        .eb_i    (opb_i[WORD_W-2 -: EXP_W]),
        .shift_i (shift),
        .exp_o   (exp_n),
        .ovf_o   (ovf_raw),
        .unf_o   (unf_raw)
    );

    hexfp_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pack (
        .zero_i (zero_in),
        .sign_i (sign),
        .exp_i  (exp_n),
        .frac_i (frac),
        .ovf_i  (ovf_raw),
        .unf_i  (unf_raw),
        .word_o (word_n),
        .ovf_o  (ovf_n),
        .unf_o  (unf_n)
    );

    // Capture the result on start and pulse done for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_o <= '0;
            ovf_o  <= 1'b0;
            unf_o  <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= start_i;
            if (start_i) begin
                prod_o <= word_n;
                ovf_o  <= ovf_n;
                unf_o  <= unf_n;
            end
        end
    end
endmodule

// File: rtl/hexfp_mul_chk.sv
// Protocol and result-shape properties for the multiplier, bound to the top.
module hexfp_mul_chk #(
    parameter int WORD_W = hexfp_pkg::WORD_W,
    parameter int FRAC_W = hexfp_pkg::FRAC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [WORD_W-1:0] opa_i,
    input logic [WORD_W-1:0] opb_i,
    input logic [WORD_W-1:0] prod_o,
    input logic              done_o,
    input logic              ovf_o,
    input logic              unf_o
);
    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) start_i |=> done_o); // R8
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n) !start_i |=> !done_o); // R8
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n) !start_i |=> ($stable(prod_o) && $stable(ovf_o) && $stable(unf_o))); // R8
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(ovf_o && unf_o)); // R9
    AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n) unf_o |-> (prod_o == '0)); // R6
    AST_OVERFLOW_SAT: assert property (@(posedge clk) disable iff (!rst_n) ovf_o |-> (prod_o[WORD_W-2:0] == '1)); // R5
    AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && ((opa_i[FRAC_W-1:0] == '0) || (opb_i[FRAC_W-1:0] == '0)))
        |=> (prod_o == '0 && !ovf_o && !unf_o)); // R7
    AST_SIGN_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (opa_i[FRAC_W-1:0] != '0) && (opb_i[FRAC_W-1:0] != '0))
        |=> (unf_o || prod_o[WORD_W-1] == ($past(opa_i[WORD_W-1]) ^ $past(opb_i[WORD_W-1])))); // R1
endmodule

bind hexfp_mul hexfp_mul_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .prod_o  (prod_o),
    .done_o  (done_o),
    .ovf_o   (ovf_o),
    .unf_o   (unf_o)
);

// File: tb/hexfp_mul_bench.sv
// Sweep of exponent edge pairs and fraction patterns with integer-computed
// expectations.
module hexfp_mul_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic [31:0] prod_o;
    logic        done_o, ovf_o, unf_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    hexfp_mul u_hexfp_mul (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .opa_i(opa_i), .opb_i(opb_i),
        .prod_o(prod_o), .done_o(done_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one operation, check the result, then check the hold cycle.
    task automatic run_one(input logic [31:0] a, input logic [31:0] b);
        logic [47:0] p;
        int          te;
        logic [23:0] f;
        logic        sh, s, zr;
        logic [31:0] ew;
        logic        eo, eu;
        string       etag;
        logic [31:0] held;
        zr = (a[23:0] == 0) || (b[23:0] == 0);
        s  = a[31] ^ b[31];
        p  = {24'd0, a[23:0]} * {24'd0, b[23:0]};
        sh = (p[47:44] == 4'd0);
        f  = sh ? p[43:20] : p[47:24];
        te = (int'(a[30:24]) - 64) + (int'(b[30:24]) - 64) - (sh ? 1 : 0);
        eo = 1'b0; eu = 1'b0;
        if (zr) begin
            ew = 32'd0; etag = "R7";
        end else if (te < -64) begin
            ew = 32'd0; eu = 1'b1; etag = "R6";
        end else if (te > 63) begin
            ew = {s, 31'h7FFFFFFF}; eo = 1'b1; etag = "R5";
        end else begin
            ew = {s, 7'(te + 64), f}; etag = sh ? "R3" : "R2";
        end
        @(negedge clk);
        opa_i = a; opb_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R8 done pulse", {31'd0, done_o}, 32'd1);
        if (!zr && !eo && !eu) begin
            chk("R1 sign", {31'd0, prod_o[31]}, {31'd0, s});
            chk({etag, " exponent"}, {25'd0, prod_o[30:24]}, {25'd0, ew[30:24]});
            chk("R4 fraction", {8'd0, prod_o[23:0]}, {8'd0, f});
        end else begin
            chk({etag, " word"}, prod_o, ew);
        end
        chk({etag, " flags"}, {30'd0, ovf_o, unf_o}, {30'd0, eo, eu});
        chk("R9 flags exclusive", {31'd0, ovf_o & unf_o}, 32'd0);
        held = prod_o;
        opa_i = ~a; opb_i = b ^ 32'h00A5A5A5;
        @(negedge clk);
        chk("R8 done falls", {31'd0, done_o}, 32'd0);
        chk("R8 word holds", prod_o, held);
    endtask

    initial begin
        logic [6:0]  exps [13];
        logic [23:0] fracs [8];
        exps  = '{7'd0, 7'd1, 7'd2, 7'd31, 7'd32, 7'd63, 7'd64, 7'd65,
                  7'd95, 7'd96, 7'd97, 7'd126, 7'd127};
        fracs = '{24'h100000, 24'hFFFFFF, 24'h123456, 24'h800000,
                  24'h1FFFFF, 24'h3C0F0A, 24'h400001, 24'hA5A5A5};
        repeat (3) @(negedge clk);
        chk("R8 reset word", prod_o, 32'd0);
        chk("R8 reset done/flags", {29'd0, done_o, ovf_o, unf_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // Zero operands in several positions and signs.
        run_one(32'h00000000, 32'h41123456);
        run_one(32'hC1800000, 32'h00000000);
        run_one(32'h7F000000, 32'hFFFFFFFF);
        run_one(32'h00000000, 32'h00000000);
        // Named corner: minimum fractions need normalization (R3).
        run_one(32'h41100000, 32'h41100000);
        // Named corner: underflow caused only by the decrement (R6).
        run_one(32'h20100000, 32'h20100000);
        // Named corner: stored exponent 128 brought back into range (R3).
        run_one(32'h60100000, 32'h60100000);
        for (int i = 0; i < 13; i++)
            for (int j = 0; j < 13; j++)
                for (int k = 0; k < 8; k++)
                    for (int m = 0; m < 8; m++)
                        run_one({1'((i + k) % 2), exps[i], fracs[k]},
                                {1'((j + m) % 3 == 0), exps[j], fracs[m]});
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule